// File: doc/BRIEF.md
# Execute Redirect Priority Resolver

This block sits at the end of the execute stage of a multi-threaded out-of-order core. Each cycle it sees up to `LANES` resolved instructions, oldest in lane 0. Each instruction carries its thread, sequence number, PC and next PC. It also carries flags from branch resolution and from the load/store queue: a branch mispredict, a memory-ordering violation, or a load that could not proceed. From these, the block picks for every thread at most one squash request and forwards it to the commit stage.

Inside one instruction, three causes compete, in fixed order: a mispredicted branch first, then an ordering violation, then a blocked load whose thread has not yet had that condition handled. Across instructions, the oldest instruction of a thread with any cause wins. Younger instructions of that thread are ignored for that cycle. Each cause sets its own redirect target and decides whether the squashing instruction is itself thrown away. The block also keeps per-thread counts of honoured mispredicts, split by the predicted direction, and a count of honoured ordering violations.

Top module: `exec_redirect_resolver`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every output is zero, and all counters are zero.
- R2: All outputs are registered: a request formed from the inputs sampled at clock edge N appears on the outputs after edge N and holds until edge N+1.
- R3: For each thread, only the lowest-numbered lane that is valid, not killed, tagged with that thread and carrying a cause produces a request. Higher lanes of that thread are ignored in that cycle.
- R4: Within the winning instruction, the cause is picked in this order: mispredict (`in_mispred`), then ordering violation (`in_order_viol`), then blocked load (`in_ld_blocked`).
- R5: A mispredict request has `sq_redirect_pc` equal to the instruction's next PC, `sq_mis_pc` equal to its PC, `sq_mispred` set and `sq_incl_self` clear.
- R6: `sq_taken` is set only on a mispredict request, and only when the next PC differs from the PC plus `INST_BYTES` (4 by default), modulo 2^`PC_W`.
- R7: An ordering-violation request has `sq_redirect_pc` equal to the next PC and `sq_incl_self` clear, and it raises that thread's `cnt_order_viol` by one.
- R8: A blocked-load request has `sq_redirect_pc` equal to the instruction's own PC and `sq_incl_self` set, and it pulses that thread's `lsq_blk_ack` high for exactly the cycle in which the request is shown.
- R9: A blocked-load flag is not a cause while `lsq_blk_handled` is high for the instruction's thread.
- R10: Lanes with `in_valid` low or `in_killed` high never produce a request.
- R11: Each honoured mispredict raises `cnt_taken_wrong` when `in_pred_taken` was set, and `cnt_ntaken_wrong` otherwise. It always raises `cnt_mispred`. All counters wrap modulo 2^`CNT_W`, so `cnt_mispred` always equals the sum of the other two modulo that size.
- R12: While a thread's `sq_valid` is low, its sequence number, both PCs, `sq_mispred`, `sq_taken`, `sq_incl_self` and `lsq_blk_ack` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LANES | Lane holds a resolved instruction |
| in_killed | input | LANES | Instruction was already squashed |
| in_tid | input | LANES*TID_W | Thread of each lane |
| in_seq | input | LANES*SEQ_W | Sequence number of each lane |
| in_pc | input | LANES*PC_W | PC of each lane |
| in_npc | input | LANES*PC_W | Resolved next PC of each lane |
| in_mispred | input | LANES | Branch resolved against its prediction |
| in_pred_taken | input | LANES | Branch had been predicted taken |
| in_order_viol | input | LANES | Memory-ordering violation raised by this instruction |
| in_ld_blocked | input | LANES | Load could not proceed |
| lsq_blk_handled | input | THREADS | Blocked-load condition already handled, per thread |
| sq_valid | output | THREADS | Squash request for the thread |
| sq_seq | output | THREADS*SEQ_W | Sequence number of the squashing instruction |
| sq_redirect_pc | output | THREADS*PC_W | Address to restart fetch from |
| sq_mis_pc | output | THREADS*PC_W | PC of the mispredicted branch |
| sq_mispred | output | THREADS | Request comes from a mispredict |
| sq_taken | output | THREADS | Mispredicted branch was actually taken |
| sq_incl_self | output | THREADS | Squashing instruction is squashed too |
| lsq_blk_ack | output | THREADS | Blocked-load condition handled |
| cnt_taken_wrong | output | THREADS*CNT_W | Mispredicts on predicted-taken branches |
| cnt_ntaken_wrong | output | THREADS*CNT_W | Mispredicts on predicted-not-taken branches |
| cnt_mispred | output | THREADS*CNT_W | All honoured mispredicts |
| cnt_order_viol | output | THREADS*CNT_W | Honoured ordering violations |

## Verification
The bench builds the block with three lanes, two threads, 8-bit sequence numbers, 16-bit PCs and 8-bit counters. With two threads, lanes of different threads share one cycle, so each thread's oldest-lane choice is checked while the other thread is active. With 8-bit counters, a few thousand random cycles make every counter wrap, which checks the modulo sum. With 16-bit PCs, a PC near the top of the address space makes PC plus `INST_BYTES` roll over in the taken check. Directed cycles first set up the cause-priority, handled-flag and killed-lane corners. A random phase then follows.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    RC_NONE   = 2'd0,
    RC_BRANCH = 2'd1,
    RC_ORDER  = 2'd2,
    RC_LDBLK  = 2'd3
  } rr_cause_e;
endpackage

// File: rtl/rr_lane_classify.sv
module rr_lane_classify
  import rr_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int TID_W   = 1
) (
  input  logic               valid,
  input  logic               killed,
  input  logic [TID_W-1:0]   tid,
  input  logic               mispred,
  input  logic               order_viol,
  input  logic               ld_blocked,
  input  logic [THREADS-1:0] blk_handled,
  output logic [1:0]         cause
);
  rr_cause_e c;

  always_comb begin
    c = RC_NONE;
    if (valid && !killed) begin
      if (mispred)                                c = RC_BRANCH;
      else if (order_viol)                        c = RC_ORDER;
      else if (ld_blocked && !blk_handled[tid])   c = RC_LDBLK;
    end
    cause = c;
  end
endmodule

// File: rtl/rr_thread_pick.sv
module rr_thread_pick
  import rr_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int TID_W      = 1,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int TID        = 0
) (
  input  logic [LANES*2-1:0]     cause,
  input  logic [LANES*TID_W-1:0] tid,
  input  logic [LANES*SEQ_W-1:0] seq,
  input  logic [LANES*PC_W-1:0]  pc,
  input  logic [LANES*PC_W-1:0]  npc,
  input  logic [LANES-1:0]       pred_taken,
  output logic                   hit,
  output logic [SEQ_W-1:0]       seq_o,
  output logic [PC_W-1:0]        redir_o,
  output logic [PC_W-1:0]        mis_o,
  output logic                   br_o,
  output logic                   taken_o,
  output logic                   incl_o,
  output logic                   ord_o,
  output logic                   ldb_o,
  output logic                   pt_o
);
  localparam logic [TID_W-1:0] MY_TID = TID_W'(TID);
  localparam logic [PC_W-1:0]  STEP   = PC_W'(INST_BYTES);

  rr_cause_e c;

  always_comb begin
    hit = 1'b0; seq_o = '0; redir_o = '0; mis_o = '0;
    br_o = 1'b0; taken_o = 1'b0; incl_o = 1'b0;
    ord_o = 1'b0; ldb_o = 1'b0; pt_o = 1'b0;
    c = RC_NONE;
    for (int l = 0; l < LANES; l++) begin
      c = rr_cause_e'(cause[2*l +: 2]);
      if (!hit && c != RC_NONE && tid[l*TID_W +: TID_W] == MY_TID) begin
        hit   = 1'b1;
        seq_o = seq[l*SEQ_W +: SEQ_W];
        case (c)
          RC_BRANCH: begin
            redir_o = npc[l*PC_W +: PC_W];
            mis_o   = pc[l*PC_W +: PC_W];
            br_o    = 1'b1;
            taken_o = npc[l*PC_W +: PC_W] != (pc[l*PC_W +: PC_W] + STEP);
            pt_o    = pred_taken[l];
          end
          RC_ORDER: begin
            redir_o = npc[l*PC_W +: PC_W];
            ord_o   = 1'b1;
          end
          default: begin
            redir_o = pc[l*PC_W +: PC_W];
            incl_o  = 1'b1;
            ldb_o   = 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rr_counters.sv
module rr_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_br,
  input  logic             br_pred_taken,
  input  logic             inc_ord,
  output logic [CNT_W-1:0] taken_wrong,
  output logic [CNT_W-1:0] ntaken_wrong,
  output logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] order_viol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      taken_wrong  <= '0;
      ntaken_wrong <= '0;
      total        <= '0;
      order_viol   <= '0;
    end else begin
      if (inc_br && br_pred_taken)  taken_wrong  <= taken_wrong + 1'b1;
      if (inc_br && !br_pred_taken) ntaken_wrong <= ntaken_wrong + 1'b1;
      if (inc_br)                   total        <= total + 1'b1;
      if (inc_ord)                  order_viol   <= order_viol + 1'b1;
    end
  end
endmodule

// File: rtl/exec_redirect_resolver.sv
module exec_redirect_resolver #(
  parameter int LANES      = 4,
  parameter int THREADS    = 2,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16,
  parameter int TID_W      = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0]         in_valid,
  input  logic [LANES-1:0]         in_killed,
  input  logic [LANES*TID_W-1:0]   in_tid,
  input  logic [LANES*SEQ_W-1:0]   in_seq,
  input  logic [LANES*PC_W-1:0]    in_pc,
  input  logic [LANES*PC_W-1:0]    in_npc,
  input  logic [LANES-1:0]         in_mispred,
  input  logic [LANES-1:0]         in_pred_taken,
  input  logic [LANES-1:0]         in_order_viol,
  input  logic [LANES-1:0]         in_ld_blocked,
  input  logic [THREADS-1:0]       lsq_blk_handled,
  output logic [THREADS-1:0]       sq_valid,
  output logic [THREADS*SEQ_W-1:0] sq_seq,
  output logic [THREADS*PC_W-1:0]  sq_redirect_pc,
  output logic [THREADS*PC_W-1:0]  sq_mis_pc,
  output logic [THREADS-1:0]       sq_mispred,
  output logic [THREADS-1:0]       sq_taken,
  output logic [THREADS-1:0]       sq_incl_self,
  output logic [THREADS-1:0]       lsq_blk_ack,
  output logic [THREADS*CNT_W-1:0] cnt_taken_wrong,
  output logic [THREADS*CNT_W-1:0] cnt_ntaken_wrong,
  output logic [THREADS*CNT_W-1:0] cnt_mispred,
  output logic [THREADS*CNT_W-1:0] cnt_order_viol
);
  logic [LANES*2-1:0] lane_cause;

  logic [THREADS-1:0]       t_hit, t_br, t_taken, t_incl, t_ord, t_ldb, t_pt;
  logic [THREADS*SEQ_W-1:0] t_seq;
  logic [THREADS*PC_W-1:0]  t_redir, t_mis;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rr_lane_classify #(.THREADS(THREADS), .TID_W(TID_W)) u_cls (
      .valid       (in_valid[l]),
      .killed      (in_killed[l]),
      .tid         (in_tid[l*TID_W +: TID_W]),
      .mispred     (in_mispred[l]),
      .order_viol  (in_order_viol[l]),
      .ld_blocked  (in_ld_blocked[l]),
      .blk_handled (lsq_blk_handled),
      .cause       (lane_cause[2*l +: 2])
    );
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    rr_thread_pick #(
      .LANES(LANES), .TID_W(TID_W), .SEQ_W(SEQ_W), .PC_W(PC_W),
      .INST_BYTES(INST_BYTES), .TID(t)
    ) u_pick (
      .cause      (lane_cause),
      .tid        (in_tid),
      .seq        (in_seq),
      .pc         (in_pc),
      .npc        (in_npc),
      .pred_taken (in_pred_taken),
      .hit        (t_hit[t]),
      .seq_o      (t_seq[t*SEQ_W +: SEQ_W]),
      .redir_o    (t_redir[t*PC_W +: PC_W]),
      .mis_o      (t_mis[t*PC_W +: PC_W]),
      .br_o       (t_br[t]),
      .taken_o    (t_taken[t]),
      .incl_o     (t_incl[t]),
      .ord_o      (t_ord[t]),
      .ldb_o      (t_ldb[t]),
      .pt_o       (t_pt[t])
    );

    rr_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk           (clk),
      .rst           (rst),
      .inc_br        (t_br[t]),
      .br_pred_taken (t_pt[t]),
      .inc_ord       (t_ord[t]),
      .taken_wrong   (cnt_taken_wrong[t*CNT_W +: CNT_W]),
      .ntaken_wrong  (cnt_ntaken_wrong[t*CNT_W +: CNT_W]),
      .total         (cnt_mispred[t*CNT_W +: CNT_W]),
      .order_viol    (cnt_order_viol[t*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_valid       <= '0;
      sq_seq         <= '0;
      sq_redirect_pc <= '0;
      sq_mis_pc      <= '0;
      sq_mispred     <= '0;
      sq_taken       <= '0;
      sq_incl_self   <= '0;
      lsq_blk_ack    <= '0;
    end else begin
      sq_valid       <= t_hit;
      sq_seq         <= t_seq;
      sq_redirect_pc <= t_redir;
      sq_mis_pc      <= t_mis;
      sq_mispred     <= t_br;
      sq_taken       <= t_taken;
      sq_incl_self   <= t_incl;
      lsq_blk_ack    <= t_ldb;
    end
  end
endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
  parameter int THREADS = 2,
  parameter int SEQ_W   = 16,
  parameter int PC_W    = 32,
  parameter int CNT_W   = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [THREADS-1:0]       sq_valid,
  input logic [THREADS*SEQ_W-1:0] sq_seq,
  input logic [THREADS*PC_W-1:0]  sq_redirect_pc,
  input logic [THREADS*PC_W-1:0]  sq_mis_pc,
  input logic [THREADS-1:0]       sq_mispred,
  input logic [THREADS-1:0]       sq_taken,
  input logic [THREADS-1:0]       sq_incl_self,
  input logic [THREADS-1:0]       lsq_blk_ack,
  input logic [THREADS*CNT_W-1:0] cnt_taken_wrong,
  input logic [THREADS*CNT_W-1:0] cnt_ntaken_wrong,
  input logic [THREADS*CNT_W-1:0] cnt_mispred
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sq_valid == '0 && lsq_blk_ack == '0));

  for (genvar t = 0; t < THREADS; t++) begin : g_t
    p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
      !sq_valid[t] |-> (sq_seq[t*SEQ_W +: SEQ_W] == '0 &&
                        sq_redirect_pc[t*PC_W +: PC_W] == '0 &&
                        sq_mis_pc[t*PC_W +: PC_W] == '0 &&
                        !sq_mispred[t] && !sq_taken[t] &&
                        !sq_incl_self[t] && !lsq_blk_ack[t]));

    p_taken_needs_mispred_r6: assert property (@(posedge clk) disable iff (rst)
      sq_taken[t] |-> sq_mispred[t]);

    p_incl_not_branch_r8: assert property (@(posedge clk) disable iff (rst)
      sq_incl_self[t] |-> (sq_valid[t] && !sq_mispred[t]));

    p_ack_with_incl_r8: assert property (@(posedge clk) disable iff (rst)
      lsq_blk_ack[t] |-> sq_incl_self[t]);

    p_total_is_sum_r11: assert property (@(posedge clk) disable iff (rst)
      cnt_mispred[t*CNT_W +: CNT_W] ==
        CNT_W'(cnt_taken_wrong[t*CNT_W +: CNT_W] + cnt_ntaken_wrong[t*CNT_W +: CNT_W]));

    p_mispred_counts_r11: assert property (@(posedge clk) disable iff (rst)
      sq_mispred[t] |-> cnt_mispred[t*CNT_W +: CNT_W] != $past(cnt_mispred[t*CNT_W +: CNT_W]));
  end
endmodule

bind exec_redirect_resolver rr_checker #(
  .THREADS(THREADS), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .sq_valid         (sq_valid),
  .sq_seq           (sq_seq),
  .sq_redirect_pc   (sq_redirect_pc),
  .sq_mis_pc        (sq_mis_pc),
  .sq_mispred       (sq_mispred),
  .sq_taken         (sq_taken),
  .sq_incl_self     (sq_incl_self),
  .lsq_blk_ack      (lsq_blk_ack),
  .cnt_taken_wrong  (cnt_taken_wrong),
  .cnt_ntaken_wrong (cnt_ntaken_wrong),
  .cnt_mispred      (cnt_mispred)
);

// File: tb/exec_redirect_resolver_tb.sv
module exec_redirect_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 3, THREADS = 2, SEQ_W = 8, PC_W = 16, INST_BYTES = 4, CNT_W = 8;
  localparam int TID_W = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [LANES-1:0]         in_valid, in_killed, in_mispred, in_pred_taken, in_order_viol, in_ld_blocked;
  logic [LANES*TID_W-1:0]   in_tid;
  logic [LANES*SEQ_W-1:0]   in_seq;
  logic [LANES*PC_W-1:0]    in_pc, in_npc;
  logic [THREADS-1:0]       lsq_blk_handled;
  logic [THREADS-1:0]       sq_valid, sq_mispred, sq_taken, sq_incl_self, lsq_blk_ack;
  logic [THREADS*SEQ_W-1:0] sq_seq;
  logic [THREADS*PC_W-1:0]  sq_redirect_pc, sq_mis_pc;
  logic [THREADS*CNT_W-1:0] cnt_taken_wrong, cnt_ntaken_wrong, cnt_mispred, cnt_order_viol;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_redirect_resolver #(
    .LANES(LANES), .THREADS(THREADS), .SEQ_W(SEQ_W), .PC_W(PC_W),
    .INST_BYTES(INST_BYTES), .CNT_W(CNT_W)
  ) u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // expected outputs, per thread
  int e_v[THREADS], e_seq[THREADS], e_rpc[THREADS], e_mpc[THREADS];
  int e_br[THREADS], e_tk[THREADS], e_inc[THREADS], e_ack[THREADS];
  int m_pt[THREADS], m_pnt[THREADS], m_tot[THREADS], m_ord[THREADS];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    in_valid = '0; in_killed = '0; in_mispred = '0; in_pred_taken = '0;
    in_order_viol = '0; in_ld_blocked = '0; in_tid = '0; in_seq = '0;
    in_pc = '0; in_npc = '0; lsq_blk_handled = '0;
  endtask

  task automatic lane(int l, int t, int sq, int pc, int npc, bit mp, bit pt, bit ov, bit lb, bit kill);
    in_valid[l] = 1'b1; in_killed[l] = kill; in_tid[l] = t[0];
    in_seq[l*SEQ_W +: SEQ_W] = SEQ_W'(sq);
    in_pc[l*PC_W +: PC_W] = PC_W'(pc); in_npc[l*PC_W +: PC_W] = PC_W'(npc);
    in_mispred[l] = mp; in_pred_taken[l] = pt; in_order_viol[l] = ov; in_ld_blocked[l] = lb;
  endtask

  // reference: oldest qualifying lane per thread, cause order per R4
  task automatic model();
    for (int t = 0; t < THREADS; t++) begin
      e_v[t] = 0; e_seq[t] = 0; e_rpc[t] = 0; e_mpc[t] = 0;
      e_br[t] = 0; e_tk[t] = 0; e_inc[t] = 0; e_ack[t] = 0;
      for (int l = 0; l < LANES; l++) begin
        int pc, npc;
        pc = int'(in_pc[l*PC_W +: PC_W]); npc = int'(in_npc[l*PC_W +: PC_W]);
        if (e_v[t] == 0 && in_valid[l] && !in_killed[l] && int'(in_tid[l]) == t) begin
          if (in_mispred[l]) begin
            e_v[t] = 1; e_rpc[t] = npc; e_mpc[t] = pc; e_br[t] = 1;
            e_tk[t] = (npc != ((pc + INST_BYTES) % 65536)) ? 1 : 0;
            if (in_pred_taken[l]) m_pt[t] = (m_pt[t] + 1) % 256;
            else m_pnt[t] = (m_pnt[t] + 1) % 256;
            m_tot[t] = (m_tot[t] + 1) % 256;
          end else if (in_order_viol[l]) begin
            e_v[t] = 1; e_rpc[t] = npc; m_ord[t] = (m_ord[t] + 1) % 256;
          end else if (in_ld_blocked[l] && !lsq_blk_handled[t]) begin
            e_v[t] = 1; e_rpc[t] = pc; e_inc[t] = 1; e_ack[t] = 1;
          end
          if (e_v[t] == 1) e_seq[t] = int'(in_seq[l*SEQ_W +: SEQ_W]);
        end
      end
    end
  endtask

  task automatic compare();
    for (int t = 0; t < THREADS; t++) begin
      string cr;
      cr = e_br[t] == 1 ? "R5" : (e_inc[t] == 1 ? "R8" : "R7");
      chk("R2 R3 R9 R10", "sq_valid", int'(sq_valid[t]), e_v[t]);
      chk("R3 R12", "sq_seq", int'(sq_seq[t*SEQ_W +: SEQ_W]), e_seq[t]);
      chk(cr, "sq_redirect_pc", int'(sq_redirect_pc[t*PC_W +: PC_W]), e_rpc[t]);
      chk("R5 R12", "sq_mis_pc", int'(sq_mis_pc[t*PC_W +: PC_W]), e_mpc[t]);
      chk("R4 R5", "sq_mispred", int'(sq_mispred[t]), e_br[t]);
      chk("R6", "sq_taken", int'(sq_taken[t]), e_tk[t]);
      chk(cr, "sq_incl_self", int'(sq_incl_self[t]), e_inc[t]);
      chk("R8", "lsq_blk_ack", int'(lsq_blk_ack[t]), e_ack[t]);
      chk("R11", "cnt_taken_wrong", int'(cnt_taken_wrong[t*CNT_W +: CNT_W]), m_pt[t]);
      chk("R11", "cnt_ntaken_wrong", int'(cnt_ntaken_wrong[t*CNT_W +: CNT_W]), m_pnt[t]);
      chk("R11", "cnt_mispred", int'(cnt_mispred[t*CNT_W +: CNT_W]), m_tot[t]);
      chk("R7", "cnt_order_viol", int'(cnt_order_viol[t*CNT_W +: CNT_W]), m_ord[t]);
    end
  endtask

  // drive the stimulus for one cycle, predict its result, check it one cycle later (R2)
  task automatic step();
    model();
    @(negedge clk);
    compare();
  endtask

  initial begin
    clear_in();
    for (int t = 0; t < THREADS; t++) begin
      e_v[t] = 0; e_seq[t] = 0; e_rpc[t] = 0; e_mpc[t] = 0; e_br[t] = 0;
      e_tk[t] = 0; e_inc[t] = 0; e_ack[t] = 0;
      m_pt[t] = 0; m_pnt[t] = 0; m_tot[t] = 0; m_ord[t] = 0;
    end
    // R1: stimulus present during reset must not leak out
    lane(0, 0, 5, 16'h100, 16'h200, 1, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    compare();
    rst = 1'b0;
    clear_in();
    step(); // R1: first cycle after reset, quiet inputs

    // R5 R6: not-taken actual (npc = pc+4), predicted taken
    clear_in(); lane(0, 0, 10, 16'h1000, 16'h1004, 1, 1, 0, 0, 0); step();
    // R6: PC wraps at top of space, npc 0 means not taken
    clear_in(); lane(1, 1, 11, 16'hFFFC, 16'h0000, 1, 0, 0, 0, 0); step();
    // R3: older violation beats younger mispredict; R8 on thread 1
    clear_in();
    lane(0, 0, 20, 16'h2000, 16'h2004, 0, 0, 1, 0, 0);
    lane(1, 1, 21, 16'h3000, 16'h3004, 0, 0, 0, 1, 0);
    lane(2, 0, 22, 16'h2008, 16'h4000, 1, 0, 0, 0, 0);
    step();
    // R9: handled blocked load ignored; R10: killed mispredict ignored; violation wins
    clear_in(); lsq_blk_handled = 2'b10;
    lane(0, 1, 30, 16'h5000, 16'h5004, 0, 0, 0, 1, 0);
    lane(1, 1, 31, 16'h5004, 16'h6000, 1, 1, 0, 0, 1);
    lane(2, 1, 32, 16'h5008, 16'h500C, 0, 0, 1, 0, 0);
    step();
    // R4: all three causes on one lane, mispredict wins
    clear_in(); lane(0, 0, 40, 16'h7000, 16'h7100, 1, 0, 1, 1, 0); step();
    // R4: violation beats blocked load
    clear_in(); lane(0, 1, 41, 16'h7200, 16'h7204, 0, 0, 1, 1, 0); step();
    // R12: idle cycle after activity
    clear_in(); step();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      clear_in();
      lsq_blk_handled = THREADS'($urandom);
      for (int l = 0; l < LANES; l++) begin
        int pc;
        pc = int'($urandom_range(0, 65535)) & 16'hFFFC;
        if ($urandom_range(0, 9) < 7)
          lane(l, int'($urandom_range(0, 1)), int'($urandom_range(0, 255)), pc,
               ($urandom_range(0, 1) == 1) ? ((pc + 4) % 65536) : int'($urandom_range(0, 65535)),
               $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
               $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
               $urandom_range(0, 5) == 0);
      end
      step();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule